// File: doc/BRIEF.md
# Life Cell Array with Relayed Diagonal Neighbours

This block is a rectangular grid of Conway Life cells, sized by parameters. Each cell is a tile with only four faces: north, east, south and west. A cell still counts all eight neighbours. Its diagonal neighbours are not wired to it directly. Each orthogonal neighbour relays one of them, turned a quarter turn clockwise. A cell sends the state it receives on its north face out of its east face. East goes out south, south goes out west, and west goes out north.

As a result, a cell's north neighbour delivers the north-east state, its east neighbour delivers the south-east state, its south neighbour delivers the south-west state, and its west neighbour delivers the north-west state.

Each generation takes two steps, and both steps use the same clock. In the capture step, every cell computes its next state and stores it in a hidden stage. In the commit step, every cell copies that stage into its visible state. While the array is stopped, the initial pattern is written one row per accepted beat on a valid/ready load stream. The whole grid is visible at all times on a flat output vector.

Top module: `life_grid`

## Requirements
- R1: After reset, every cell reads 0, the next capture step comes first, the load row pointer is at row 0, and `load_ready` is high while `run` is low.
- R2: `load_ready` equals `!run`. A beat is accepted when `load_valid && load_ready`. An accepted beat writes `load_data[c]` into cell (row pointer, c), and the change shows on `cells` after that same edge. The row pointer then advances and wraps from ROWS-1 back to 0. A beat offered while `run` is high is not taken and does not advance the pointer.
- R3: While `run` is low and no beat is accepted, `cells` does not change.
- R4: While `run` is high, the edges alternate between capture and commit, starting with capture. `cells` changes only on commit edges, so it changes on the 2nd, 4th, 6th… edge after `run` rises. If `run` falls, the next step is reset to capture, and the pending captured value is never committed.
- R5: A cell is alive in the next generation exactly when 2×(live neighbours) + (own state) lies in 5..7.
- R6: All cells capture from the same committed generation. No cell ever sees a neighbourhood that is partly updated.
- R7: Diagonal neighbours count toward the sum. A dead cell with only three live diagonal neighbours is born.
- R8: Positions outside the grid read as dead, both for direct neighbours and for relayed diagonal neighbours. The edges do not wrap around.
- R9: A blinker repeats with period 2. A glider reappears shifted one row down and one column right after 4 generations, which is 8 run edges.
- R10: `cells` bit r×COLS+c is the committed state of row r, column c. Row 0 is the top row and column 0 is the left column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Evolution enable |
| load_valid | input | 1 | A load beat is offered |
| load_ready | output | 1 | A load beat can be accepted (high only while stopped) |
| load_data | input | COLS | One row of the pattern; bit c is column c |
| cells | output | ROWS*COLS | Committed grid; bit r*COLS+c is row r, column c |

## Verification
An accepted load beat shows on `cells` right after the edge that accepts it. A generation needs two edges of `run` high, and its result shows after the second one, the commit edge. Bench inputs change at falling edges. The bench model steps forward on each rising edge and uses the inputs that were just driven, including the reset of the step order when `run` drops. The grid is compared with the model at the falling edge that follows, so every result is checked in the cycle it becomes due. Targeted checks are placed at the same falling edges: the first half-generation, an interrupted generation, a diagonal-only birth, an edge blinker, and the glider after eight run edges.

// File: rtl/life_pkg.sv
package life_pkg;

  typedef enum logic {
    STEP_CAPTURE = 1'b0,
    STEP_COMMIT  = 1'b1
  } step_e;

  // Table of next states indexed by the eight neighbour bits.
  // Entry i is keep_mask[number of ones in i].
  function automatic logic [255:0] make_count_table(input logic [8:0] keep_mask);
    logic [255:0] t;
    for (int i = 0; i < 256; i++) begin
      t[i] = keep_mask[$countones(i[7:0])];
    end
    return t;
  endfunction

endpackage

// File: rtl/life_rule.sv
module life_rule #(
  parameter int          RULE_STYLE = 0,      // 0: weighted window, 1: lookup table
  parameter int          WIN_LO     = 5,
  parameter int          WIN_HI     = 7,
  parameter logic [8:0]  BORN_MASK  = 9'b000001000,
  parameter logic [8:0]  STAY_MASK  = 9'b000001100
) (
  input  logic [7:0] nbr,
  input  logic       own,
  output logic       nxt
);
  localparam int SUM_W = 5;

  generate
    if (RULE_STYLE == 0) begin : g_window
      logic [SUM_W-1:0] live;
      logic [SUM_W-1:0] weighted;
      always_comb begin
        live     = SUM_W'($countones(nbr));
        weighted = {live[SUM_W-2:0], 1'b0} + SUM_W'(own);
      end
      logic starve_ok, crowd_ok;
      assign starve_ok = (weighted >= SUM_W'(WIN_LO));
      assign crowd_ok  = (weighted <= SUM_W'(WIN_HI));
      assign nxt       = starve_ok & crowd_ok;
    end else begin : g_table
      localparam logic [255:0] BORN_TAB = life_pkg::make_count_table(BORN_MASK);
      localparam logic [255:0] STAY_TAB = life_pkg::make_count_table(STAY_MASK);
      assign nxt = own ? STAY_TAB[nbr] : BORN_TAB[nbr];
    end
  endgenerate

endmodule

// File: rtl/life_step.sv
module life_step (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic cap_en,
  output logic com_en
);
  import life_pkg::*;

  step_e step_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= STEP_CAPTURE;
    end else if (!run) begin
      step_q <= STEP_CAPTURE;
    end else begin
      step_q <= (step_q == STEP_CAPTURE) ? STEP_COMMIT : STEP_CAPTURE;
    end
  end

  assign cap_en = run && (step_q == STEP_CAPTURE);
  assign com_en = run && (step_q == STEP_COMMIT);

  AST_COMMIT_FOLLOWS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    com_en |-> $past(cap_en));  // R4
  AST_STOP_RESTARTS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && rst_n) |=> !com_en);  // R4

endmodule

// File: rtl/life_loader.sv
module life_loader #(
  parameter int ROWS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            load_valid,
  output logic            load_ready,
  output logic [ROWS-1:0] row_we
);
  localparam int PTR_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam logic [PTR_W-1:0] LAST_ROW = PTR_W'(ROWS - 1);

  logic [PTR_W-1:0] ptr_q;
  logic             take;

  assign load_ready = !run;
  assign take       = load_valid && load_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (take) begin
      ptr_q <= (ptr_q == LAST_ROW) ? '0 : ptr_q + 1'b1;
    end
  end

  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_we
      assign row_we[r] = take && (ptr_q == PTR_W'(r));
    end
  endgenerate

  AST_NO_LOAD_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (row_we == '0));  // R2
  AST_PTR_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ptr_q == LAST_ROW) |=> (ptr_q == '0));  // R2
  AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(ptr_q));  // R2

endmodule

// File: rtl/life_cell.sv
module life_cell #(
  parameter int RULE_STYLE = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic com_en,
  input  logic ld_we,
  input  logic ld_bit,
  // direct neighbour states, one per face
  input  logic in_n_self,
  input  logic in_e_self,
  input  logic in_s_self,
  input  logic in_w_self,
  // relayed diagonal states, one per face
  input  logic in_n_relay,   // north-east
  input  logic in_e_relay,   // south-east
  input  logic in_s_relay,   // south-west
  input  logic in_w_relay,   // north-west
  output logic state,
  // quarter-turn relays leaving each face
  output logic out_e_relay,
  output logic out_s_relay,
  output logic out_w_relay,
  output logic out_n_relay
);
  logic       held_q;
  logic       state_q;
  logic       nxt;
  logic [7:0] nbr;

  assign nbr = {in_n_self, in_e_self, in_s_self, in_w_self,
                in_n_relay, in_e_relay, in_s_relay, in_w_relay};

  life_rule #(.RULE_STYLE(RULE_STYLE)) u_rule (
    .nbr (nbr),
    .own (state_q),
    .nxt (nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      state_q <= 1'b0;
    end else begin
      if (cap_en) held_q <= nxt;
      if (com_en)      state_q <= held_q;
      else if (ld_we)  state_q <= ld_bit;
    end
  end

  assign state       = state_q;
  assign out_e_relay = in_n_self;
  assign out_s_relay = in_e_self;
  assign out_w_relay = in_s_self;
  assign out_n_relay = in_w_self;

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!com_en && !ld_we) |=> $stable(state_q));  // R3
  AST_COMMIT_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    com_en |=> (state_q == $past(held_q)));  // R6
  AST_CAPTURE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> $stable(state_q));  // R4

endmodule

// File: rtl/life_grid.sv
module life_grid #(
  parameter int ROWS       = 8,
  parameter int COLS       = 8,
  parameter int RULE_STYLE = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 load_valid,
  output logic                 load_ready,
  input  logic [COLS-1:0]      load_data,
  output logic [ROWS*COLS-1:0] cells
);
  localparam int CELLS = ROWS * COLS;

  logic            cap_en, com_en;
  logic [ROWS-1:0] row_we;

  logic [ROWS-1:0][COLS-1:0] st;
  logic [ROWS-1:0][COLS-1:0] rel_e, rel_s, rel_w, rel_n;

  life_step u_step (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .cap_en (cap_en),
    .com_en (com_en)
  );

  life_loader #(.ROWS(ROWS)) u_loader (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .load_valid (load_valid),
    .load_ready (load_ready),
    .row_we     (row_we)
  );

  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
        logic n_s, e_s, s_s, w_s;
        logic n_r, e_r, s_r, w_r;

        if (r > 0) begin : g_has_n
          assign n_s = st[r-1][c];
          assign n_r = rel_s[r-1][c];
        end else begin : g_edge_n
          assign n_s = 1'b0;
          assign n_r = 1'b0;
        end

        if (c < COLS-1) begin : g_has_e
          assign e_s = st[r][c+1];
          assign e_r = rel_w[r][c+1];
        end else begin : g_edge_e
          assign e_s = 1'b0;
          assign e_r = 1'b0;
        end

        if (r < ROWS-1) begin : g_has_s
          assign s_s = st[r+1][c];
          assign s_r = rel_n[r+1][c];
        end else begin : g_edge_s
          assign s_s = 1'b0;
          assign s_r = 1'b0;
        end

        if (c > 0) begin : g_has_w
          assign w_s = st[r][c-1];
          assign w_r = rel_e[r][c-1];
        end else begin : g_edge_w
          assign w_s = 1'b0;
          assign w_r = 1'b0;
        end

        life_cell #(.RULE_STYLE(RULE_STYLE)) u_cell (
          .clk         (clk),
          .rst_n       (rst_n),
          .cap_en      (cap_en),
          .com_en      (com_en),
          .ld_we       (row_we[r]),
          .ld_bit      (load_data[c]),
          .in_n_self   (n_s),
          .in_e_self   (e_s),
          .in_s_self   (s_s),
          .in_w_self   (w_s),
          .in_n_relay  (n_r),
          .in_e_relay  (e_r),
          .in_s_relay  (s_r),
          .in_w_relay  (w_r),
          .state       (st[r][c]),
          .out_e_relay (rel_e[r][c]),
          .out_s_relay (rel_s[r][c]),
          .out_w_relay (rel_w[r][c]),
          .out_n_relay (rel_n[r][c])
        );

        assign cells[r*COLS + c] = st[r][c];
      end
    end
  endgenerate

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cap_en, com_en, |row_we}));  // R6
  AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(load_valid && load_ready)) |=> $stable(cells));  // R3
  AST_READY_TRACKS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    load_ready == !run);  // R2

  initial begin
    AST_GRID_NONEMPTY: assert (CELLS > 0);  // R10
  end

endmodule

// File: tb/tb_life_grid.sv
`timescale 1ns/1ps
module tb_life_grid;
  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam int N    = ROWS * COLS;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           run;
  logic           load_valid;
  logic           load_ready;
  logic [COLS-1:0] load_data;
  logic [N-1:0]   cells;

  always #10 clk = ~clk;

  life_grid #(.ROWS(ROWS), .COLS(COLS)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .load_valid (load_valid),
    .load_ready (load_ready),
    .load_data  (load_data),
    .cells      (cells)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural model
  bit [N-1:0] m_grid;
  bit [N-1:0] m_held;
  bit         m_commit_next;
  int         m_ptr;

  function automatic int idx(int r, int c);
    return r * COLS + c;
  endfunction

  function automatic bit alive_at(bit [N-1:0] g, int r, int c);
    if (r < 0 || r >= ROWS || c < 0 || c >= COLS) return 1'b0;
    return g[idx(r, c)];
  endfunction

  function automatic bit [N-1:0] life_gen(bit [N-1:0] g);
    bit [N-1:0] o = '0;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        int k = 0;
        for (int dr = -1; dr <= 1; dr++)
          for (int dc = -1; dc <= 1; dc++)
            if (!(dr == 0 && dc == 0)) k += alive_at(g, r + dr, c + dc);
        o[idx(r, c)] = (k == 3) || (g[idx(r, c)] && k == 2);
      end
    end
    return o;
  endfunction

  function automatic bit [N-1:0] shift_dr(bit [N-1:0] g);
    bit [N-1:0] o = '0;
    for (int r = 0; r < ROWS-1; r++)
      for (int c = 0; c < COLS-1; c++)
        o[idx(r+1, c+1)] = g[idx(r, c)];
    return o;
  endfunction

  task automatic model_edge();
    if (!rst_n) begin
      m_grid = '0; m_held = '0; m_commit_next = 0; m_ptr = 0;
    end else if (run) begin
      if (!m_commit_next) begin
        m_held = life_gen(m_grid);
        m_commit_next = 1;
      end else begin
        m_grid = m_held;
        m_commit_next = 0;
      end
    end else begin
      m_commit_next = 0;
      if (load_valid) begin
        for (int c = 0; c < COLS; c++) m_grid[idx(m_ptr, c)] = load_data[c];
        m_ptr = (m_ptr == ROWS-1) ? 0 : m_ptr + 1;
      end
    end
  endtask

  task automatic check(bit ok, string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    if (rst_n) begin
      check(cells === m_grid, "R4 R5 R6 per-cycle grid", cells, m_grid);
      check(load_ready === !run, "R2 ready per-cycle", N'(load_ready), N'(!run));
    end
  endtask

  task automatic load_frame(bit [N-1:0] p);
    run = 0;
    for (int r = 0; r < ROWS; r++) begin
      load_valid = 1;
      for (int c = 0; c < COLS; c++) load_data[c] = p[idx(r, c)];
      tick();
    end
    load_valid = 0;
    load_data  = '0;
  endtask

  task automatic run_edges(int n);
    run = 1;
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [N-1:0] p, start, hold;
    rst_n = 0; run = 0; load_valid = 0; load_data = '0;
    tick(); tick();
    rst_n = 1;
    tick();
    check(cells === '0, "R1 reset grid", cells, '0);
    check(load_ready === 1'b1, "R1 ready after reset", N'(load_ready), N'(1));

    // R2 / R10: one row beat lands on the addressed row, visible after the edge
    p = '0; p[idx(3,2)] = 1; p[idx(3,3)] = 1; p[idx(3,4)] = 1;
    load_frame(p);
    check(cells === p, "R2 R10 loaded blinker", cells, p);

    // R3: stopped, nothing offered
    for (int i = 0; i < 3; i++) tick();
    check(cells === p, "R3 frozen when stopped", cells, p);

    // R2: beat offered while running is refused (one capture edge happens too)
    run = 1; load_valid = 1; load_data = '1;
    tick();
    load_valid = 0; load_data = '0;
    check(cells === p, "R2 R4 refused beat, capture only", cells, p);
    tick();
    hold = '0; hold[idx(2,3)] = 1; hold[idx(3,3)] = 1; hold[idx(4,3)] = 1;
    check(cells === hold, "R5 blinker turns vertical", cells, hold);
    run_edges(2);
    check(cells === p, "R9 blinker period 2", cells, p);

    // R4: interrupted generation
    run = 1; tick();
    run = 0; tick();
    check(cells === p, "R4 interrupted generation discarded", cells, p);
    run_edges(1);
    check(cells === p, "R4 restart begins with capture", cells, p);
    run_edges(1);
    check(cells === hold, "R4 commit on second edge", cells, hold);

    // R7: diagonal-only birth
    p = '0; p[idx(1,1)] = 1; p[idx(1,3)] = 1; p[idx(3,1)] = 1;
    load_frame(p);
    run_edges(2);
    check(cells[idx(2,2)] === 1'b1, "R7 diagonal birth", N'(cells[idx(2,2)]), N'(1));

    // R8: blinker on the left edge
    p = '0; p[idx(2,0)] = 1; p[idx(3,0)] = 1; p[idx(4,0)] = 1;
    load_frame(p);
    run_edges(2);
    hold = '0; hold[idx(3,0)] = 1; hold[idx(3,1)] = 1;
    check(cells === hold, "R8 dead outside edge", cells, hold);
    check(cells[idx(3,COLS-1)] === 1'b0, "R8 no wrap", N'(cells[idx(3,COLS-1)]), N'(0));

    // R9: glider moves one diagonal step in 4 generations
    start = '0;
    start[idx(0,1)] = 1; start[idx(1,2)] = 1;
    start[idx(2,0)] = 1; start[idx(2,1)] = 1; start[idx(2,2)] = 1;
    load_frame(start);
    run_edges(8);
    hold = shift_dr(start);
    check(cells === hold, "R9 glider shifted", cells, hold);
    run_edges(8);
    hold = shift_dr(hold);
    check(cells === hold, "R9 glider shifted twice", cells, hold);

    run = 0;
    tick();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule